// File: doc/BRIEF.md
# TLB Zone Protection Checker

This block settles the access rights of one memory request per cycle once the TLB has found a matching entry. It takes the entry's data word, the 32-bit zone protection register, the privilege of the requester and the kind of access. It picks a 4-bit zone index out of the entry, looks up a 2-bit zone code for that index in the protection register, and applies the code's override rules to the page's own execute and write bits. The result is a set of read, execute and write grants and a protection-fault flag, all registered.

Two build-time parameters shape the lookup. `MMU_LEVEL` set to 1 builds a core without zones, so every access behaves as if the zone code were 1. `NUM_ZONES` gives the highest implemented zone index. An index above it is treated as code 1, and it also raises a sticky diagnostic flag that software clears through `diag_clear`. The TLB search, page sizes and exception dispatch belong to neighbouring blocks.

Top module: `zone_prot_check`

## Requirements
- R1: The zone index is `tlb_data[7:4]`. The raw zone code for index z is `zpr[31-2z : 30-2z]`, so zone 0 is held in `zpr[31:30]` and zone 15 in `zpr[1:0]`. The effective code appears on `zone_code`.
- R2: When the zone index is greater than `NUM_ZONES`, the effective zone code is 1, whatever the protection register holds.
- R3: When `MMU_LEVEL` is 1, the effective zone code is always 1.
- R4: Code 0 with `req_user`=1 grants no read, execute or write. Code 0 with `req_user`=0 grants read, and takes execute from page bit `tlb_data[9]` and write from page bit `tlb_data[8]`.
- R5: Code 1 grants read and takes execute and write from the page bits (`tlb_data[9]`, `tlb_data[8]`). Code 2 does the same for user requests, and grants read, execute and write to supervisor requests.
- R6: Code 3 grants read, execute and write, whatever the page bits hold.
- R7: Read is granted in every case except code 0 with a user request.
- R8: `req_acc` encodes 0 = fetch, 1 = load, 2 = store, and 3 is handled as a load. `prot_fault` is raised for a fetch without execute, a store without write, and a load without read.
- R9: All results appear one clock after the request. `rsp_valid` is `req_valid` delayed by one clock. `prot_fault` is high only together with `rsp_valid`. On a cycle with `req_valid` low, `zone_code` and the three grants keep their previous values.
- R10: `zone_range_err` goes high the clock after a valid request whose zone index exceeds `NUM_ZONES`. It stays high until a cycle with `diag_clear`=1 and no such request, and is low on the clock after that cycle. When setting and clearing happen in the same cycle, setting wins.
- R11: While `rst_n` is low, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | A request is present this cycle |
| req_user | input | 1 | 1 = user mode, 0 = supervisor |
| req_acc | input | 2 | Access kind: 0 fetch, 1 load, 2 store, 3 load |
| tlb_data | input | DATA_W (32) | Data word of the matching TLB entry |
| zpr | input | 32 | Zone protection register, two bits per zone |
| diag_clear | input | 1 | Clears the sticky out-of-range flag |
| rsp_valid | output | 1 | Results below belong to last cycle's request |
| zone_code | output | 2 | Effective zone code |
| perm_rd | output | 1 | Read granted |
| perm_ex | output | 1 | Execute granted |
| perm_wr | output | 1 | Write granted |
| prot_fault | output | 1 | The access kind lacks its grant |
| zone_range_err | output | 1 | Sticky: a zone index above NUM_ZONES was used |

## Verification
The lookup and the flag are the only state here, so any fault shows at the ports on the clock after the request that exposes it. A wrong shift in the zone lookup shows as a wrong `zone_code` for particular indices, so every index is driven against an asymmetric register pattern. A missed override shows as a raw code leaking through for indices above the limit, or on the zone-less build. A broken sticky flag shows as `zone_range_err` dropping early or never clearing. A reference model compares every output on every clock, so the first wrong cycle is reported.

// File: rtl/zp_pkg.sv
package zp_pkg;
  localparam int ZSEL_W = 4;
  localparam int ZONES_MAX = 1 << ZSEL_W;
  localparam int ZPR_W = 2 * ZONES_MAX;

  typedef enum logic [1:0] {
    ACC_FETCH = 2'd0,
    ACC_LOAD  = 2'd1,
    ACC_STORE = 2'd2,
    ACC_ALT   = 2'd3
  } acc_e;

  typedef struct packed {
    logic rd;
    logic ex;
    logic wr;
  } perm_t;

  // Two-bit code of one zone; zone 0 lives in the top pair of bits.
  function automatic logic [1:0] zone_field(input logic [ZPR_W-1:0] zpr,
                                            input logic [ZSEL_W-1:0] zsel);
    logic [ZPR_W-1:0] shifted;
    shifted = zpr >> (ZPR_W - 2 - 2 * int'(zsel));
    return shifted[1:0];
  endfunction

  // Apply the zone override rules to the page bits.
  function automatic perm_t resolve(input logic [1:0] code, input logic user,
                                    input logic pg_ex, input logic pg_wr);
    perm_t p;
    p = '{rd: 1'b1, ex: pg_ex, wr: pg_wr};
    case (code)
      2'd0: if (user) p = '{rd: 1'b0, ex: 1'b0, wr: 1'b0};
      2'd2: if (!user) p = '{rd: 1'b1, ex: 1'b1, wr: 1'b1};
      2'd3: p = '{rd: 1'b1, ex: 1'b1, wr: 1'b1};
      default: ;
    endcase
    return p;
  endfunction

  function automatic logic lacks_grant(input acc_e acc, input perm_t p);
    case (acc)
      ACC_FETCH: return !p.ex;
      ACC_STORE: return !p.wr;
      default:   return !p.rd;
    endcase
  endfunction
endpackage

// File: rtl/zp_zone_select.sv
module zp_zone_select
  import zp_pkg::*;
#(
  parameter int NUM_ZONES = 15,
  parameter int MMU_LEVEL = 3
) (
  input  logic [ZSEL_W-1:0] zsel,
  input  logic [ZPR_W-1:0]  zpr,
  output logic [1:0]        eff_code,
  output logic              out_of_range
);
  localparam bit ZONES_OFF = (MMU_LEVEL == 1);

  logic [1:0] raw_code;

  always_comb begin
    raw_code     = zone_field(zpr, zsel);
    out_of_range = (int'({1'b0, zsel}) > NUM_ZONES);
    eff_code     = (ZONES_OFF || out_of_range) ? 2'd1 : raw_code;
  end
endmodule

// File: rtl/zp_perm_resolve.sv
module zp_perm_resolve
  import zp_pkg::*;
(
  input  logic [1:0] code,
  input  logic       user,
  input  logic       pg_ex,
  input  logic       pg_wr,
  input  acc_e       acc,
  output perm_t      perm,
  output logic       fault
);
  always_comb begin
    perm  = resolve(code, user, pg_ex, pg_wr);
    fault = lacks_grant(acc, perm);
  end
endmodule

// File: rtl/zp_diag_flag.sv
module zp_diag_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic flag
);
  always_ff @(posedge clk) begin
    if (!rst_n)   flag <= 1'b0;
    else if (set) flag <= 1'b1;
    else if (clr) flag <= 1'b0;
  end

  // R10
  sticky_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set |=> flag);

  // R10
  sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !clr) |=> flag);
endmodule

// File: rtl/zone_prot_check.sv
module zone_prot_check
  import zp_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int ZSEL_LSB  = 4,
  parameter int PG_WR_BIT = 8,
  parameter int PG_EX_BIT = 9,
  parameter int NUM_ZONES = 15,
  parameter int MMU_LEVEL = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_user,
  input  logic [1:0]        req_acc,
  input  logic [DATA_W-1:0] tlb_data,
  input  logic [ZPR_W-1:0]  zpr,
  input  logic              diag_clear,
  output logic              rsp_valid,
  output logic [1:0]        zone_code,
  output logic              perm_rd,
  output logic              perm_ex,
  output logic              perm_wr,
  output logic              prot_fault,
  output logic              zone_range_err
);
  logic [ZSEL_W-1:0] zsel_w;
  logic [1:0]        code_w;
  logic              oor_w;
  perm_t             perm_w;
  logic              fault_w;
  logic              data_unused;

  assign zsel_w      = tlb_data[ZSEL_LSB +: ZSEL_W];
  assign data_unused = ^tlb_data;

  zp_zone_select #(.NUM_ZONES(NUM_ZONES), .MMU_LEVEL(MMU_LEVEL)) u_sel (
    .zsel(zsel_w), .zpr(zpr), .eff_code(code_w), .out_of_range(oor_w)
  );

  zp_perm_resolve u_perm (
    .code(code_w), .user(req_user), .pg_ex(tlb_data[PG_EX_BIT]),
    .pg_wr(tlb_data[PG_WR_BIT]), .acc(acc_e'(req_acc)),
    .perm(perm_w), .fault(fault_w)
  );

  zp_diag_flag u_diag (
    .clk(clk), .rst_n(rst_n), .set(req_valid && oor_w),
    .clr(diag_clear), .flag(zone_range_err)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid  <= 1'b0;
      prot_fault <= 1'b0;
      zone_code  <= 2'd0;
      perm_rd    <= 1'b0;
      perm_ex    <= 1'b0;
      perm_wr    <= 1'b0;
    end else begin
      rsp_valid  <= req_valid;
      prot_fault <= req_valid && fault_w;
      if (req_valid) begin
        zone_code <= code_w;
        perm_rd   <= perm_w.rd;
        perm_ex   <= perm_w.ex;
        perm_wr   <= perm_w.wr;
      end
    end
  end

  // R9
  fault_needs_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    prot_fault |-> rsp_valid);

  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> (!rsp_valid && $stable(zone_code) && $stable(perm_wr)));

  // R6
  code3_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && zone_code == 2'd3) |-> (perm_rd && perm_ex && perm_wr));

  // R7
  read_unless_code0_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && zone_code != 2'd0) |-> perm_rd);

  // R2
  range_override_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && oor_w) |=> (zone_code == 2'd1 && zone_range_err));

  generate
    if (MMU_LEVEL == 1) begin : g_nozones
      // R3
      zones_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> zone_code == 2'd1);
    end
  endgenerate
endmodule

// File: tb/sim_zone_prot_check.sv
`timescale 1ns/1ps
module sim_zone_prot_check;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_user = 1'b0, diag_clear = 1'b0;
  logic [1:0] req_acc = 2'd0;
  logic [31:0] tlb_data = 32'd0, zpr = 32'd0;

  logic rv [2];
  logic [1:0] zc [2];
  logic prd [2], pex [2], pwr [2], flt [2], dg [2];

  int n_checks = 0, n_fail = 0;
  bit done = 0;

  // expected state per instance
  int e_rv [2], e_zc [2], e_rd [2], e_ex [2], e_wr [2], e_flt [2], e_dg [2];
  int nz_of [2] = '{11, 3};
  int lvl_of [2] = '{3, 1};

  always #2 clk = ~clk;

  zone_prot_check #(.NUM_ZONES(11), .MMU_LEVEL(3)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_user(req_user),
    .req_acc(req_acc), .tlb_data(tlb_data), .zpr(zpr), .diag_clear(diag_clear),
    .rsp_valid(rv[0]), .zone_code(zc[0]), .perm_rd(prd[0]), .perm_ex(pex[0]),
    .perm_wr(pwr[0]), .prot_fault(flt[0]), .zone_range_err(dg[0]));

  zone_prot_check #(.NUM_ZONES(3), .MMU_LEVEL(1)) u1 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_user(req_user),
    .req_acc(req_acc), .tlb_data(tlb_data), .zpr(zpr), .diag_clear(diag_clear),
    .rsp_valid(rv[1]), .zone_code(zc[1]), .perm_rd(prd[1]), .perm_ex(pex[1]),
    .perm_wr(pwr[1]), .prot_fault(flt[1]), .zone_range_err(dg[1]));

  task automatic check(input string tag, input int inst, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s (u%0d) at %0t: actual %0d expected %0d", tag, inst, $time, act, exp);
    end
  endtask

  task automatic compare_all();
    for (int i = 0; i < 2; i++) begin
      check("R9 rsp_valid", i, int'(rv[i]), e_rv[i]);
      check("R1,R2,R3 zone code", i, int'(zc[i]), e_zc[i]);
      check("R4,R5,R6,R7 read", i, int'(prd[i]), e_rd[i]);
      check("R4,R5,R6 execute", i, int'(pex[i]), e_ex[i]);
      check("R4,R5,R6 write", i, int'(pwr[i]), e_wr[i]);
      check("R8 fault", i, int'(flt[i]), e_flt[i]);
      check("R10 range flag", i, int'(dg[i]), e_dg[i]);
    end
  endtask

  // Behavioural model of the next-cycle outputs for one instance.
  task automatic model(input int i, input bit v, input bit u, input int acc,
                       input logic [31:0] d, input logic [31:0] z, input bit c);
    int zi, code, rd, ex, wr, need;
    bit oor;
    zi = (d / 16) % 16;
    code = {z[31 - 2*zi], z[30 - 2*zi]};
    oor = (zi > nz_of[i]);
    if (oor || lvl_of[i] == 1) code = 1;
    rd = 1; ex = d[9]; wr = d[8];
    if (code == 3 || (code == 2 && !u)) begin ex = 1; wr = 1; end
    if (code == 0 && u) begin rd = 0; ex = 0; wr = 0; end
    if (acc == 0) need = ex; else if (acc == 2) need = wr; else need = rd;
    e_rv[i] = v;
    e_flt[i] = (v && need == 0) ? 1 : 0;
    if (v) begin e_zc[i] = code; e_rd[i] = rd; e_ex[i] = ex; e_wr[i] = wr; end
    if (v && oor) e_dg[i] = 1; else if (c) e_dg[i] = 0;
  endtask

  task automatic step(input bit v, input bit u, input int acc,
                      input logic [31:0] d, input logic [31:0] z, input bit c);
    @(negedge clk);
    compare_all();
    req_valid = v; req_user = u; req_acc = 2'(acc);
    tlb_data = d; zpr = z; diag_clear = c;
    for (int i = 0; i < 2; i++) model(i, v, u, acc, d, z, c);
  endtask

  function automatic logic [31:0] ent(input int zi, input bit pex_b, input bit pwr_b);
    return 32'(zi * 16 + pwr_b * 256 + pex_b * 512);
  endfunction

  initial begin
    for (int i = 0; i < 2; i++) begin
      e_rv[i] = 0; e_zc[i] = 0; e_rd[i] = 0; e_ex[i] = 0;
      e_wr[i] = 0; e_flt[i] = 0; e_dg[i] = 0;
    end
    // R11: outputs low during reset, even with a request applied
    req_valid = 1'b1; tlb_data = ent(13, 1, 1); zpr = 32'hFFFF_FFFF;
    repeat (3) @(negedge clk);
    compare_all();
    req_valid = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;

    // R1: every zone index against pattern 3,2,1,0 repeated (zone 0 = 3)
    for (int zi = 0; zi < 16; zi++)
      for (int u = 0; u < 2; u++)
        for (int acc = 0; acc < 4; acc++)
          step(1, u[0], acc, ent(zi, 0, 0), 32'hE4E4_E4E4, 0);
    // R4,R5,R6: each code with each page-bit combination
    for (int code = 0; code < 4; code++)
      for (int pb = 0; pb < 4; pb++)
        for (int u = 0; u < 2; u++)
          for (int acc = 0; acc < 3; acc++)
            step(1, u[0], acc, ent(2, pb[1], pb[0]), 32'(code) << 26, 0);
    // R9: idle cycles hold the previous result
    step(1, 1, 2, ent(1, 1, 0), 32'h0000_0000, 0);
    step(0, 0, 0, ent(5, 1, 1), 32'hFFFF_FFFF, 0);
    step(0, 1, 1, ent(7, 0, 0), 32'h5555_5555, 0);
    // R2,R10: out-of-range index sets the flag; clear, and set-wins-over-clear
    step(1, 1, 0, ent(14, 0, 0), 32'h0000_0000, 0);
    step(0, 0, 0, 32'd0, 32'd0, 0);
    step(0, 0, 0, 32'd0, 32'd0, 1);
    step(0, 0, 0, 32'd0, 32'd0, 0);
    step(1, 0, 1, ent(12, 0, 0), 32'h0000_0000, 1);
    step(0, 0, 0, 32'd0, 32'd0, 0);
    step(0, 0, 0, 32'd0, 32'd0, 1);
    step(1, 1, 2, ent(15, 1, 0), 32'h0000_0000, 0);
    // random traffic
    for (int k = 0; k < 3000; k++)
      step(($urandom % 8) != 0, $urandom % 2, $urandom % 4,
           $urandom, $urandom, ($urandom % 16) == 0);
    step(0, 0, 0, 32'd0, 32'd0, 0);
    step(0, 0, 0, 32'd0, 32'd0, 0);
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      done = 1;
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule